// File: doc/BRIEF.md
# Single-Step Game Control Unit

This block is the control unit and datapath of a small two-player game. It owns an eight-entry, 16-bit register file and a three-operation ALU (add, pass operand A, equality compare), and drives the file's write port through an operand A select, an operand B select and a write-data select. Its inputs are clean one-cycle pulses: a start event, a timer tick, two player presses, and a manual advance pulse. Player presses carry a data word that reaches the register file through the write-data select.

For debugging, the controller runs in step mode. Every state that computes and writes holds its controls and does not change state until an advance pulse arrives. Only in that cycle does it commit the write and move on, so a held state writes its destination once. States that wait for an outside event take no advance. A per-state debug code is registered onto an output. One compare state waits a fixed settle count before it captures its result. A parameter ties advance high, so the same controller also runs at full speed.

Top module: `step_game_ctrl`

## Requirements
- R1: Synchronous reset puts the controller in START, clears the debug code to 0 and the settle counter to 0, and zeroes all eight registers.
- R2: START never writes and ignores advance, tick and player presses; a start pulse alone moves it to SET_POINTS.
- R3: In a compute state (SET_POINTS, RESET_TIMER, UPDATE_SCORE, CHECK, BRANCH) the state and its controls hold until advance is 1. The write enable is asserted only in that cycle, so each visit writes its destination exactly once.
- R4: SET_POINTS writes 1 into register 4 and goes to RESET_TIMER. RESET_TIMER writes TIMER_INIT (default 25) into register 1 and goes to IDLE.
- R5: IDLE gives priority to tick (go to CHECK, no write), then player 1 (write the press data into register 2, stay in IDLE), then player 2 (write the press data into register 3, go to UPDATE_SCORE). With no event, IDLE holds the write enable at 0.
- R6: UPDATE_SCORE writes register 3 plus register 4 into register 3 and goes to RESET_TIMER.
- R7: CHECK compares register 1 with 10 and writes 1 (equal) or 0 into register 6. A 10-bit counter counts its cycles. The write comes only once the counter is all ones, which at full speed means exactly 1024 cycles in CHECK. In step mode CHECK then waits for advance. The counter clears as CHECK exits to BRANCH.
- R8: BRANCH writes nothing. On advance it goes to UPDATE_SCORE if register 6 is nonzero, and to IDLE otherwise.
- R9: The debug output equals the code of the state held one cycle earlier: START 1, SET_POINTS 2, RESET_TIMER 4, IDLE 5, CHECK 6, UPDATE_SCORE 8, BRANCH 9.
- R10: With STEP_EN = 0 the advance input is ignored and every compute state commits in its first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| advance_i | input | 1 | Manual step pulse |
| start_i | input | 1 | Start event pulse |
| p1_i | input | 1 | Player 1 press pulse |
| p2_i | input | 1 | Player 2 press pulse |
| tick_i | input | 1 | Timer tick pulse |
| pin_data_i | input | 16 | Data carried by a player press |
| peek_addr_i | input | 3 | Debug read address into the register file |
| peek_data_o | output | 16 | Debug read data |
| rf_we_o | output | 1 | Register file write enable |
| rf_wa_o | output | 3 | Register file write address |
| rf_wd_o | output | 16 | Register file write data |
| dbg_code_o | output | 8 | Registered per-state debug code |

## Verification
Two pairs of functions can fall in the same cycle. The first is IDLE's three event paths: tick and both player presses are pulsed together, then player 1 and player 2 alone, and the bench judges the result from the debug code and the register contents. The second is the advance pulse arriving together with event pulses while the controller sits in START. That pair must leave both the state and every register untouched. A scoreboard queue holds every write the requirements allow, so any extra write or repeated write shows up as a mismatch. A second instance, built at full speed with a timer constant that makes the compare true, measures the exact length of the settle window and the taken branch.

// File: rtl/step_game_pkg.sv
package step_game_pkg;

  localparam int RF_AW = 3;
  localparam int DBG_W = 8;

  localparam logic [RF_AW-1:0] REG_TIMER  = 3'd1;
  localparam logic [RF_AW-1:0] REG_P1     = 3'd2;
  localparam logic [RF_AW-1:0] REG_SCORE  = 3'd3;
  localparam logic [RF_AW-1:0] REG_POINTS = 3'd4;
  localparam logic [RF_AW-1:0] REG_FLAG   = 3'd6;

  typedef enum logic [2:0] {
    ST_START, ST_SETPTS, ST_RSTTMR, ST_IDLE, ST_CHECK, ST_BRANCH, ST_UPDATE
  } gstate_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_PASSA, ALU_CMPEQ} aluop_e;
  typedef enum logic [1:0] {ASEL_RD1, ASEL_ONE, ASEL_TINIT} asel_e;
  typedef enum logic {BSEL_RD2, BSEL_CONST} bsel_e;
  typedef enum logic {WD_ALU, WD_PIN} wdsel_e;

  function automatic logic [DBG_W-1:0] dbg_code_f(input gstate_e s);
    case (s)
      ST_START:  return 8'd1;
      ST_SETPTS: return 8'd2;
      ST_RSTTMR: return 8'd4;
      ST_IDLE:   return 8'd5;
      ST_CHECK:  return 8'd6;
      ST_UPDATE: return 8'd8;
      ST_BRANCH: return 8'd9;
      default:   return 8'd0;
    endcase
  endfunction

  function automatic logic is_compute_f(input gstate_e s);
    return (s == ST_SETPTS) || (s == ST_RSTTMR) || (s == ST_CHECK) ||
           (s == ST_BRANCH) || (s == ST_UPDATE);
  endfunction

endpackage

// File: rtl/sgc_regfile.sv
module sgc_regfile
  import step_game_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RF_AW-1:0]  wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [RF_AW-1:0]  ra1,
  output logic [DATA_W-1:0] rd1,
  input  logic [RF_AW-1:0]  ra2,
  output logic [DATA_W-1:0] rd2,
  input  logic [RF_AW-1:0]  ra3,
  output logic [DATA_W-1:0] rd3
);
  localparam int NREG = 1 << RF_AW;

  logic [DATA_W-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        mem[g] <= '0;
      else if (we && (wa == RF_AW'(g)))
        mem[g] <= wd;
    end
  end

  assign rd1 = mem[ra1];
  assign rd2 = mem[ra2];
  assign rd3 = mem[ra3];
endmodule

// File: rtl/sgc_datapath.sv
module sgc_datapath
  import step_game_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int TIMER_INIT = 25,
  parameter int CMP_CONST  = 10
) (
  input  aluop_e            aluop,
  input  asel_e             asel,
  input  bsel_e             bsel,
  input  wdsel_e            wdsel,
  input  logic [DATA_W-1:0] rd1,
  input  logic [DATA_W-1:0] rd2,
  input  logic [DATA_W-1:0] pin,
  output logic [DATA_W-1:0] a_mux,
  output logic [DATA_W-1:0] b_mux,
  output logic [DATA_W-1:0] alu_y,
  output logic [DATA_W-1:0] wd
);
  localparam logic [DATA_W-1:0] K_ONE   = DATA_W'(1);
  localparam logic [DATA_W-1:0] K_TINIT = DATA_W'(TIMER_INIT);
  localparam logic [DATA_W-1:0] K_CMP   = DATA_W'(CMP_CONST);

  function automatic logic [DATA_W-1:0] alu_f(input aluop_e op,
                                               input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
    case (op)
      ALU_ADD:   return a + b;
      ALU_CMPEQ: return {{(DATA_W-1){1'b0}}, (a == b)};
      default:   return a;
    endcase
  endfunction

  always_comb begin
    case (asel)
      ASEL_ONE:   a_mux = K_ONE;
      ASEL_TINIT: a_mux = K_TINIT;
      default:    a_mux = rd1;
    endcase
  end

  assign b_mux = (bsel == BSEL_CONST) ? K_CMP : rd2;
  assign alu_y = alu_f(aluop, a_mux, b_mux);
  assign wd    = (wdsel == WD_PIN) ? pin : alu_y;
endmodule

// File: rtl/sgc_fsm.sv
module sgc_fsm
  import step_game_pkg::*;
#(
  parameter int DLY_W   = 10,
  parameter bit STEP_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic             start,
  input  logic             p1,
  input  logic             p2,
  input  logic             tick,
  input  logic             flag_nz,
  output gstate_e          state_o,
  output logic             adv_eff_o,
  output logic [DLY_W-1:0] cnt_o,
  output logic [DBG_W-1:0] dbg_o,
  output aluop_e           aluop,
  output asel_e            asel,
  output bsel_e            bsel,
  output wdsel_e           wdsel,
  output logic [RF_AW-1:0] ra1,
  output logic [RF_AW-1:0] ra2,
  output logic [RF_AW-1:0] wa,
  output logic             we
);
  gstate_e          st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic [DBG_W-1:0] dbg_q;
  logic             adv;
  logic             settled;

  if (STEP_EN) begin : g_step
    assign adv = advance;
  end else begin : g_fast
    assign adv = 1'b1;
  end

  assign settled = &cnt_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    we    = 1'b0;
    wa    = '0;
    ra1   = '0;
    ra2   = '0;
    aluop = ALU_PASSA;
    asel  = ASEL_RD1;
    bsel  = BSEL_RD2;
    wdsel = WD_ALU;
    case (st_q)
      ST_START: begin
        if (start) st_d = ST_SETPTS;
      end
      ST_SETPTS: begin
        asel = ASEL_ONE;
        wa   = REG_POINTS;
        if (adv) begin
          we   = 1'b1;
          st_d = ST_RSTTMR;
        end
      end
      ST_RSTTMR: begin
        asel = ASEL_TINIT;
        wa   = REG_TIMER;
        if (adv) begin
          we   = 1'b1;
          st_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (tick) begin
          st_d = ST_CHECK;
        end else if (p1) begin
          wdsel = WD_PIN;
          wa    = REG_P1;
          we    = 1'b1;
        end else if (p2) begin
          wdsel = WD_PIN;
          wa    = REG_SCORE;
          we    = 1'b1;
          st_d  = ST_UPDATE;
        end
      end
      ST_UPDATE: begin
        aluop = ALU_ADD;
        ra1   = REG_SCORE;
        ra2   = REG_POINTS;
        wa    = REG_SCORE;
        if (adv) begin
          we   = 1'b1;
          st_d = ST_RSTTMR;
        end
      end
      ST_CHECK: begin
        aluop = ALU_CMPEQ;
        ra1   = REG_TIMER;
        bsel  = BSEL_CONST;
        wa    = REG_FLAG;
        if (!settled) begin
          cnt_d = cnt_q + 1'b1;
        end else if (adv) begin
          we    = 1'b1;
          cnt_d = '0;
          st_d  = ST_BRANCH;
        end
      end
      ST_BRANCH: begin
        ra1 = REG_FLAG;
        if (adv) st_d = flag_nz ? ST_UPDATE : ST_IDLE;
      end
      default: st_d = ST_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_START;
      cnt_q <= '0;
      dbg_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      dbg_q <= dbg_code_f(st_q);
    end
  end

  assign state_o   = st_q;
  assign adv_eff_o = adv;
  assign cnt_o     = cnt_q;
  assign dbg_o     = dbg_q;
endmodule

// File: rtl/step_game_ctrl.sv
module step_game_ctrl
  import step_game_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int DLY_W      = 10,
  parameter int TIMER_INIT = 25,
  parameter int CMP_CONST  = 10,
  parameter bit STEP_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance_i,
  input  logic              start_i,
  input  logic              p1_i,
  input  logic              p2_i,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] pin_data_i,
  input  logic [RF_AW-1:0]  peek_addr_i,
  output logic [DATA_W-1:0] peek_data_o,
  output logic              rf_we_o,
  output logic [RF_AW-1:0]  rf_wa_o,
  output logic [DATA_W-1:0] rf_wd_o,
  output logic [DBG_W-1:0]  dbg_code_o
);
  gstate_e           state_q;
  logic              adv_eff;
  logic [DLY_W-1:0]  dly_cnt;
  aluop_e            aluop;
  asel_e             asel;
  bsel_e             bsel;
  wdsel_e            wdsel;
  logic [RF_AW-1:0]  ra1, ra2, wa;
  logic              we;
  logic [DATA_W-1:0] rd1, rd2, a_mux, b_mux, alu_y, wd;
  logic              flag_nz;

  assign flag_nz = |rd1;

  sgc_fsm #(.DLY_W(DLY_W), .STEP_EN(STEP_EN)) u_fsm (
    .clk(clk), .rst(rst), .advance(advance_i), .start(start_i),
    .p1(p1_i), .p2(p2_i), .tick(tick_i), .flag_nz(flag_nz),
    .state_o(state_q), .adv_eff_o(adv_eff), .cnt_o(dly_cnt), .dbg_o(dbg_code_o),
    .aluop(aluop), .asel(asel), .bsel(bsel), .wdsel(wdsel),
    .ra1(ra1), .ra2(ra2), .wa(wa), .we(we)
  );

  sgc_datapath #(.DATA_W(DATA_W), .TIMER_INIT(TIMER_INIT), .CMP_CONST(CMP_CONST)) u_dp (
    .aluop(aluop), .asel(asel), .bsel(bsel), .wdsel(wdsel),
    .rd1(rd1), .rd2(rd2), .pin(pin_data_i),
    .a_mux(a_mux), .b_mux(b_mux), .alu_y(alu_y), .wd(wd)
  );

  sgc_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst(rst), .we(we), .wa(wa), .wd(wd),
    .ra1(ra1), .rd1(rd1), .ra2(ra2), .rd2(rd2),
    .ra3(peek_addr_i), .rd3(peek_data_o)
  );

  assign rf_we_o = we;
  assign rf_wa_o = wa;
  assign rf_wd_o = wd;
endmodule

// File: rtl/sgc_checker.sv
module sgc_checker
  import step_game_pkg::*;
#(
  parameter int DLY_W = 10
) (
  input logic             clk,
  input logic             rst,
  input gstate_e          st,
  input logic             adv_eff,
  input logic             tick,
  input logic             p1,
  input logic             p2,
  input logic             we,
  input logic [RF_AW-1:0] wa,
  input logic [DBG_W-1:0] dbg,
  input logic [DLY_W-1:0] cnt
);
  // R3
  comp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (is_compute_f(st) && !adv_eff) |=> (st == $past(st)));

  // R3
  comp_we_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (is_compute_f(st) && we) |-> adv_eff);

  // R3
  write_once_chk: assert property (@(posedge clk) disable iff (rst)
    (is_compute_f(st) && we) |=> (st != $past(st)));

  // R2
  start_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START) |-> !we);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !tick && !p1 && !p2) |-> !we);

  // R5
  tick_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && tick) |=> (st == ST_CHECK));

  // R5
  p1_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !tick && p1) |-> (we && wa == REG_P1));

  // R7
  settle_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CHECK && !(&cnt)) |-> !we);

  // R9
  dbg_code_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (dbg == dbg_code_f($past(st))));
endmodule

bind step_game_ctrl sgc_checker #(.DLY_W(DLY_W)) u_sgc_checker (
  .clk(clk), .rst(rst), .st(state_q), .adv_eff(adv_eff),
  .tick(tick_i), .p1(p1_i), .p2(p2_i), .we(rf_we_o), .wa(rf_wa_o),
  .dbg(dbg_code_o), .cnt(dly_cnt)
);

// File: tb/step_game_ctrl_bench.sv
`timescale 1ns/1ps
module step_game_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  // step-mode instance
  logic        adv = 0, st_p = 0, p1 = 0, p2 = 0, tk = 0;
  logic [15:0] pin = 0, pk_s;
  logic [2:0]  pa_s = 0;
  logic        we_s;
  logic [2:0]  wa_s;
  logic [15:0] wd_s;
  logic [7:0]  dbg_s;

  // full-speed instance
  logic        st_f = 0, tk_f = 0;
  logic [15:0] pk_f, wd_f;
  logic [2:0]  pa_f = 0, wa_f;
  logic        we_f;
  logic [7:0]  dbg_f;

  int n_cmp = 0, n_bad = 0;
  logic [18:0] exp_q[$];

  step_game_ctrl u_step_game_ctrl (
    .clk(clk), .rst(rst), .advance_i(adv), .start_i(st_p), .p1_i(p1), .p2_i(p2),
    .tick_i(tk), .pin_data_i(pin), .peek_addr_i(pa_s), .peek_data_o(pk_s),
    .rf_we_o(we_s), .rf_wa_o(wa_s), .rf_wd_o(wd_s), .dbg_code_o(dbg_s));

  step_game_ctrl #(.TIMER_INIT(10), .STEP_EN(1'b0)) u_step_game_ctrl_fast (
    .clk(clk), .rst(rst), .advance_i(1'b0), .start_i(st_f), .p1_i(1'b0), .p2_i(1'b0),
    .tick_i(tk_f), .pin_data_i(16'd0), .peek_addr_i(pa_f), .peek_data_o(pk_f),
    .rf_we_o(we_f), .rf_wa_o(wa_f), .rf_wd_o(wd_f), .dbg_code_o(dbg_f));

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // wait n falling edges, then settle into the middle of the low phase
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1.5;
  endtask

  task automatic peek_s(input logic [2:0] a, output logic [15:0] d);
    pa_s = a; #0.2; d = pk_s;
  endtask

  task automatic peek_f(input logic [2:0] a, output logic [15:0] d);
    pa_f = a; #0.2; d = pk_f;
  endtask

  // one-cycle pulse on any mix of the step-instance event inputs
  task automatic pulse(input logic a, input logic s, input logic x1, input logic x2,
                       input logic t, input logic [15:0] d);
    @(negedge clk);
    adv = a; st_p = s; p1 = x1; p2 = x2; tk = t; pin = d;
    @(negedge clk);
    adv = 0; st_p = 0; p1 = 0; p2 = 0; tk = 0;
  endtask

  task automatic expect_wr(input logic [2:0] a, input logic [15:0] d);
    exp_q.push_back({a, d});
  endtask

  // monitor: every write of the step instance must match the next queued item
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && we_s) begin
        if (exp_q.size() == 0) begin
          chk("R3 unexpected write addr", {29'd0, wa_s}, 32'd99);
        end else begin
          logic [18:0] e;
          e = exp_q.pop_front();
          chk("R3 write addr", {29'd0, wa_s}, {29'd0, e[18:16]});
          chk("R3 write data", {16'd0, wd_s}, {16'd0, e[15:0]});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    logic [15:0] v;
    int run;
    repeat (3) @(negedge clk);
    #1.5;
    // R1 reset state
    chk("R1 debug in reset", {24'd0, dbg_s}, 0);
    for (int i = 0; i < 8; i++) begin
      peek_s(3'(i), v);
      chk("R1 register zero", {16'd0, v}, 0);
    end
    @(negedge clk);
    rst = 0;
    wait_cyc(3);
    chk("R9 START code", {24'd0, dbg_s}, 1);

    // R2 advance and events in START do nothing
    pulse(1, 0, 1, 0, 1, 16'd5);
    wait_cyc(2);
    chk("R2 START holds", {24'd0, dbg_s}, 1);
    peek_s(3'd2, v); chk("R2 no player write", {16'd0, v}, 0);

    pulse(0, 1, 0, 0, 0, 0);
    wait_cyc(5);
    chk("R9 SET_POINTS code", {24'd0, dbg_s}, 2);
    peek_s(3'd4, v); chk("R3 no write before advance", {16'd0, v}, 0);

    // R4 constants
    expect_wr(3'd4, 16'd1);
    pulse(1, 0, 0, 0, 0, 0);
    wait_cyc(2);
    chk("R9 RESET_TIMER code", {24'd0, dbg_s}, 4);
    peek_s(3'd4, v); chk("R4 points register", {16'd0, v}, 1);
    expect_wr(3'd1, 16'd25);
    pulse(1, 0, 0, 0, 0, 0);
    wait_cyc(2);
    chk("R9 IDLE code", {24'd0, dbg_s}, 5);
    peek_s(3'd1, v); chk("R4 timer register", {16'd0, v}, 25);

    // R5 idle without events, then player paths
    wait_cyc(4);
    expect_wr(3'd2, 16'd7);
    pulse(0, 0, 1, 0, 0, 16'd7);
    wait_cyc(2);
    chk("R5 p1 stays IDLE", {24'd0, dbg_s}, 5);
    peek_s(3'd2, v); chk("R5 p1 data", {16'd0, v}, 7);

    expect_wr(3'd2, 16'd9);
    pulse(0, 0, 1, 1, 0, 16'd9);
    wait_cyc(2);
    peek_s(3'd2, v); chk("R5 p1 over p2 reg2", {16'd0, v}, 9);
    peek_s(3'd3, v); chk("R5 p1 over p2 reg3", {16'd0, v}, 0);
    chk("R5 p1 over p2 state", {24'd0, dbg_s}, 5);

    expect_wr(3'd3, 16'd3);
    pulse(0, 0, 0, 1, 0, 16'd3);
    wait_cyc(6);
    chk("R9 UPDATE_SCORE code", {24'd0, dbg_s}, 8);
    peek_s(3'd3, v); chk("R3 update held", {16'd0, v}, 3);

    // R6 score add
    expect_wr(3'd3, 16'd4);
    pulse(1, 0, 0, 0, 0, 0);
    wait_cyc(2);
    peek_s(3'd3, v); chk("R6 sum written once", {16'd0, v}, 4);
    chk("R6 to RESET_TIMER", {24'd0, dbg_s}, 4);
    expect_wr(3'd1, 16'd25);
    pulse(1, 0, 0, 0, 0, 0);
    wait_cyc(2);
    chk("R4 back to IDLE", {24'd0, dbg_s}, 5);

    // R5 tick beats both players
    pulse(0, 0, 1, 1, 1, 16'd11);
    wait_cyc(2);
    chk("R5 tick to CHECK", {24'd0, dbg_s}, 6);
    peek_s(3'd2, v); chk("R5 tick blocks p1", {16'd0, v}, 9);
    peek_s(3'd3, v); chk("R5 tick blocks p2", {16'd0, v}, 4);

    // R7 step mode waits past the settle window for advance
    wait_cyc(1100);
    chk("R7 CHECK waits for advance", {24'd0, dbg_s}, 6);
    expect_wr(3'd6, 16'd0);
    pulse(1, 0, 0, 0, 0, 0);
    wait_cyc(2);
    chk("R8 BRANCH code", {24'd0, dbg_s}, 9);
    peek_s(3'd6, v); chk("R7 unequal flag", {16'd0, v}, 0);
    wait_cyc(3);
    chk("R8 BRANCH holds", {24'd0, dbg_s}, 9);
    pulse(1, 0, 0, 0, 0, 0);
    wait_cyc(2);
    chk("R8 zero flag to IDLE", {24'd0, dbg_s}, 5);
    chk("R3 all writes seen", exp_q.size(), 0);

    // R10 full-speed instance
    @(negedge clk); st_f = 1;
    @(negedge clk); st_f = 0;
    wait_cyc(4);
    chk("R10 fast reaches IDLE", {24'd0, dbg_f}, 5);
    peek_f(3'd4, v); chk("R10 fast points", {16'd0, v}, 1);
    peek_f(3'd1, v); chk("R10 fast timer", {16'd0, v}, 10);
    @(negedge clk); tk_f = 1;
    @(negedge clk); tk_f = 0;
    run = 0;
    for (int i = 0; i < 20 && dbg_f != 8'd6; i++) wait_cyc(1);
    for (int i = 0; i < 3000 && dbg_f == 8'd6; i++) begin
      run++;
      wait_cyc(1);
    end
    chk("R7 settle window length", run, 1024);
    wait_cyc(6);
    peek_f(3'd6, v); chk("R7 equal flag", {16'd0, v}, 1);
    peek_f(3'd3, v); chk("R8 taken branch updates score", {16'd0, v}, 1);
    chk("R8 fast back to IDLE", {24'd0, dbg_f}, 5);
    report();
  end
endmodule